// File: doc/BRIEF.md
# EDO DRAM Controller with Power-Up Initialization

This block sits between a synchronous host and an asynchronous 16-bit EDO DRAM. The host hands over one word request at a time: an address, a read or write flag, write data and two byte enables. The controller turns each request into a single RAS/CAS cycle. It splits the address into a row and a column and drives them onto a shared address bus. It sequences the active-low row strobe, the two byte column strobes, the write strobe and the output enable. It also drives or releases the data bus. Every interval is a whole number of clocks, set by a parameter.

After reset the controller keeps every strobe inactive for a parameterized pause. It then runs a fixed number of CAS-before-RAS refresh cycles, and only after that does it offer the host its ready signal. From then on, a refresh timer asks for a CAS-before-RAS refresh at a set interval. A pending refresh wins over a waiting host request but never cuts into a cycle that has already started. Writes always use early-write timing: WE falls before any CAS strobe, so the memory keeps its outputs high-impedance and the controller may drive the bus for the whole cycle.

The request side is a valid/ready stream. A request transfers on a clock edge where `req_valid` and `req_ready` are both high. The host holds its fields stable while `req_valid` is high and may keep `req_valid` high across stalls. `req_ready` drops for the whole cycle that follows an acceptance and while a refresh is pending or running. The read response is a single-cycle `rsp_valid` pulse with no back-pressure. The host must take `rsp_rdata` in that cycle.

Top module: `edo_ctrl`

## Requirements
- R1: From reset until PAUSE_CYC clocks have passed, ram_ras_n, ram_ucas_n, ram_lcas_n, ram_we_n and ram_oe_n stay high (inactive) and req_ready stays low.
- R2: After the pause, exactly INIT_REF CAS-before-RAS refresh cycles run, and no host access takes place, before req_ready is first raised.
- R3: In every refresh cycle, both CAS strobes are low for at least T_CSR clocks before RAS falls. During the refresh, ram_we_n and ram_oe_n stay high.
- R4: In a write, ram_we_n is already low on the clock before a CAS strobe falls. ram_oe_n stays high and ram_dq_oe stays high while CAS is low, and the write data is on ram_dq_out.
- R5: The CAS strobes are never staggered. In a write, ram_ucas_n (data bits 15:8) falls if req_be[1] is set and ram_lcas_n (bits 7:0) falls if req_be[0] is set, and those that fall do so on the same edge. A read lowers both strobes on the same edge.
- R6: The row, req_addr[ROW_W+COL_W-1:COL_W], is on ram_addr at least one clock before RAS falls. The column, req_addr[COL_W-1:0] zero-extended, is on ram_addr at least one clock before CAS falls. ram_addr does not change on the edge where either strobe falls.
- R7: In a read, ram_oe_n falls with CAS and stays low without a break for SAMPLE cycles. SAMPLE is the largest of T_RAC-T_RCD-1, T_AA-1 and T_CAC, and at least 1. The data on ram_dq_in at the end of that window is returned on rsp_rdata with a one-cycle rsp_valid pulse.
- R8: Between any two periods of RAS low, ram_ras_n is high for at least T_RP clocks.
- R9: After initialization, a refresh request is raised every REF_INTERVAL clocks. The refresh starts as soon as the controller is idle, ahead of any waiting host request, so refreshes are never further apart than REF_INTERVAL plus one access cycle.
- R10: req_ready is high only when the controller is idle, with all strobes high and no refresh pending. Each accepted request produces exactly one memory cycle, and each accepted read produces exactly one response.
- R11: ram_dq_oe and an active ram_oe_n are never high and low in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request is valid |
| req_ready | output | 1 | Controller accepts a request this clock |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ROW_W+COL_W | Word address, row in the upper bits |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables, bit 1 = upper byte |
| rsp_valid | output | 1 | One-cycle read response strobe |
| rsp_rdata | output | 16 | Read data |
| ram_addr | output | max(ROW_W,COL_W) | Multiplexed row/column address |
| ram_ras_n | output | 1 | Row strobe, active low |
| ram_ucas_n | output | 1 | Upper-byte column strobe, active low |
| ram_lcas_n | output | 1 | Lower-byte column strobe, active low |
| ram_we_n | output | 1 | Write strobe, active low |
| ram_oe_n | output | 1 | Output enable, active low |
| ram_dq_out | output | 16 | Data driven toward the memory |
| ram_dq_oe | output | 1 | Controller drives the data bus |
| ram_dq_in | input | 16 | Data returned by the memory |

## Verification
The bench builds the controller with ROW_W=5 and COL_W=4, so the column must be zero-padded on a 5-bit address bus. A behavioural memory of 512 words is enough to hold every address. The pause is shrunk to 30 clocks and the refresh interval to 300 clocks, which makes the full eight-cycle initialization and several periodic refreshes fit in a short run. Access timings of T_RAC=6, T_AA=3 and T_CAC=2 make the row-access term decide the sample point (3 clocks), and that term differs from both other candidates. Mixed byte-enable writes and reads are then issued back to back while refreshes fall due, to exercise arbitration.

// File: rtl/edo_pkg.sv
package edo_pkg;
  localparam int DQ_W = 16;
  localparam int BE_W = 2;

  typedef enum logic [3:0] {
    ST_PAUSE,
    ST_REF_CAS,
    ST_REF_RAS,
    ST_PRECH,
    ST_IDLE,
    ST_ROW,
    ST_RAS,
    ST_COL,
    ST_CAS
  } edo_state_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    return max2(a, max2(b, c));
  endfunction
endpackage

// File: rtl/edo_refresh_timer.sv
module edo_refresh_timer #(
  parameter int INTERVAL = 1950
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic ack,
  output logic pend
);
  localparam int TW = $clog2(INTERVAL + 1);
  logic [TW-1:0] tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick <= '0;
      pend <= 1'b0;
    end else begin
      if (ack) pend <= 1'b0;
      if (en) begin
        if (tick == TW'(INTERVAL - 1)) begin
          tick <= '0;
          pend <= 1'b1;
        end else begin
          tick <= tick + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/edo_addr_mux.sv
module edo_addr_mux #(
  parameter int ROW_W = 10,
  parameter int COL_W = 9,
  parameter int A_W   = 10
) (
  input  logic [ROW_W-1:0] row,
  input  logic [COL_W-1:0] col,
  input  logic             sel_col,
  output logic [A_W-1:0]   addr
);
  logic [A_W-1:0] row_x, col_x;

  generate
    if (ROW_W == COL_W) begin : g_same
      assign row_x = row;
      assign col_x = col;
    end else if (ROW_W > COL_W) begin : g_pad_col
      assign row_x = row;
      assign col_x = {{(A_W-COL_W){1'b0}}, col};
    end else begin : g_pad_row
      assign row_x = {{(A_W-ROW_W){1'b0}}, row};
      assign col_x = col;
    end
  endgenerate

  assign addr = sel_col ? col_x : row_x;
endmodule

// File: rtl/edo_seq.sv
module edo_seq import edo_pkg::*; #(
  parameter int ROW_W      = 10,
  parameter int COL_W      = 9,
  parameter int PAUSE_CYC  = 25000,
  parameter int INIT_REF   = 8,
  parameter int T_RCD      = 3,
  parameter int T_RP       = 4,
  parameter int T_CSR      = 1,
  parameter int T_RASR     = 6,
  parameter int T_CASW     = 2,
  parameter int SAMPLE_CYC = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ref_pend,
  output logic                   ref_ack,
  output logic                   init_done,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_write,
  input  logic [ROW_W+COL_W-1:0] req_addr,
  input  logic [DQ_W-1:0]        req_wdata,
  input  logic [BE_W-1:0]        req_be,
  output logic                   rsp_valid,
  output logic [DQ_W-1:0]        rsp_rdata,
  output logic                   ras_n,
  output logic                   ucas_n,
  output logic                   lcas_n,
  output logic                   we_n,
  output logic                   oe_n,
  output logic                   dq_oe,
  output logic [DQ_W-1:0]        dq_out,
  input  logic [DQ_W-1:0]        dq_in,
  output logic                   sel_col,
  output logic [ROW_W-1:0]       row,
  output logic [COL_W-1:0]       col
);
  localparam int LONGEST = max2(PAUSE_CYC,
                                max3(max3(T_RCD, T_RP, T_CSR), T_RASR, max2(T_CASW, SAMPLE_CYC)));
  localparam int CW = $clog2(LONGEST + 1);
  localparam int IW = $clog2(INIT_REF + 1);

  edo_state_e                st;
  logic [CW-1:0]             cnt, last;
  logic [IW-1:0]             init_cnt;
  logic                      wr_q;
  logic [BE_W-1:0]           be_q;
  logic [ROW_W+COL_W-1:0]    addr_q;
  logic [DQ_W-1:0]           wdata_q;
  logic                      done, access, refresh;

  always_comb begin
    case (st)
      ST_PAUSE:   last = CW'(PAUSE_CYC - 1);
      ST_REF_CAS: last = CW'(T_CSR - 1);
      ST_REF_RAS: last = CW'(T_RASR - 1);
      ST_PRECH:   last = CW'(T_RP - 1);
      ST_RAS:     last = CW'(T_RCD - 1);
      ST_CAS:     last = wr_q ? CW'(T_CASW - 1) : CW'(SAMPLE_CYC - 1);
      default:    last = '0;
    endcase
  end
  assign done = (cnt == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_PAUSE;
      cnt       <= '0;
      init_cnt  <= '0;
      init_done <= 1'b0;
      wr_q      <= 1'b0;
      be_q      <= '0;
      addr_q    <= '0;
      wdata_q   <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= 1'b0;
      cnt <= (st != ST_IDLE && !done) ? cnt + 1'b1 : '0;
      case (st)
        ST_PAUSE:   if (done) st <= ST_REF_CAS;
        ST_REF_CAS: if (done) st <= ST_REF_RAS;
        ST_REF_RAS: if (done) begin
          st <= ST_PRECH;
          if (!init_done) init_cnt <= init_cnt + 1'b1;
        end
        ST_PRECH: if (done) begin
          if (!init_done && init_cnt < IW'(INIT_REF)) st <= ST_REF_CAS;
          else begin
            init_done <= 1'b1;
            st        <= ST_IDLE;
          end
        end
        ST_IDLE: begin
          if (ref_pend) st <= ST_REF_CAS;
          else if (req_valid) begin
            wr_q    <= req_write;
            be_q    <= req_be;
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            st      <= ST_ROW;
          end
        end
        ST_ROW: if (done) st <= ST_RAS;
        ST_RAS: if (done) st <= ST_COL;
        ST_COL: if (done) st <= ST_CAS;
        ST_CAS: if (done) begin
          st <= ST_PRECH;
          if (!wr_q) begin
            rsp_valid <= 1'b1;
            rsp_rdata <= dq_in;
          end
        end
        default: st <= ST_PAUSE;
      endcase
    end
  end

  // strobe decode from the registered state
  assign access  = (st == ST_ROW) || (st == ST_RAS) || (st == ST_COL) || (st == ST_CAS);
  assign refresh = (st == ST_REF_CAS) || (st == ST_REF_RAS);

  assign ras_n   = !((st == ST_RAS) || (st == ST_COL) || (st == ST_CAS) || (st == ST_REF_RAS));
  assign ucas_n  = !(refresh || (st == ST_CAS && (!wr_q || be_q[1])));
  assign lcas_n  = !(refresh || (st == ST_CAS && (!wr_q || be_q[0])));
  assign we_n    = !(wr_q && access);
  assign oe_n    = !(!wr_q && st == ST_CAS);
  assign dq_oe   = wr_q && access;
  assign dq_out  = wdata_q;
  assign sel_col = (st == ST_COL) || (st == ST_CAS);
  assign row     = addr_q[ROW_W+COL_W-1:COL_W];
  assign col     = addr_q[COL_W-1:0];

  assign ref_ack   = (st == ST_IDLE) && ref_pend;
  assign req_ready = (st == ST_IDLE) && !ref_pend;
endmodule

// File: rtl/edo_ctrl.sv
module edo_ctrl import edo_pkg::*; #(
  parameter int ROW_W        = 10,
  parameter int COL_W        = 9,
  parameter int PAUSE_CYC    = 25000,
  parameter int INIT_REF     = 8,
  parameter int REF_INTERVAL = 1950,
  parameter int T_RCD        = 3,
  parameter int T_RP         = 4,
  parameter int T_CSR        = 1,
  parameter int T_RASR       = 6,
  parameter int T_CASW       = 2,
  parameter int T_RAC        = 7,
  parameter int T_AA         = 4,
  parameter int T_CAC        = 2,
  parameter int A_W          = max2(ROW_W, COL_W)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_write,
  input  logic [ROW_W+COL_W-1:0] req_addr,
  input  logic [15:0]            req_wdata,
  input  logic [1:0]             req_be,
  output logic                   rsp_valid,
  output logic [15:0]            rsp_rdata,
  output logic [A_W-1:0]         ram_addr,
  output logic                   ram_ras_n,
  output logic                   ram_ucas_n,
  output logic                   ram_lcas_n,
  output logic                   ram_we_n,
  output logic                   ram_oe_n,
  output logic [15:0]            ram_dq_out,
  output logic                   ram_dq_oe,
  input  logic [15:0]            ram_dq_in
);
  // clocks from CAS fall until read data is valid: the slowest access path wins
  localparam int SAMPLE_CYC = max2(max3(T_RAC - T_RCD - 1, T_AA - 1, T_CAC), 1);

  logic             ref_pend, ref_ack, init_done, sel_col;
  logic [ROW_W-1:0] row;
  logic [COL_W-1:0] col;

  edo_refresh_timer #(.INTERVAL(REF_INTERVAL)) u_timer (
    .clk(clk), .rst_n(rst_n), .en(init_done), .ack(ref_ack), .pend(ref_pend)
  );

  edo_seq #(
    .ROW_W(ROW_W), .COL_W(COL_W), .PAUSE_CYC(PAUSE_CYC), .INIT_REF(INIT_REF),
    .T_RCD(T_RCD), .T_RP(T_RP), .T_CSR(T_CSR), .T_RASR(T_RASR),
    .T_CASW(T_CASW), .SAMPLE_CYC(SAMPLE_CYC)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .ref_pend(ref_pend), .ref_ack(ref_ack),
    .init_done(init_done), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_be(req_be), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .ras_n(ram_ras_n), .ucas_n(ram_ucas_n), .lcas_n(ram_lcas_n),
    .we_n(ram_we_n), .oe_n(ram_oe_n), .dq_oe(ram_dq_oe), .dq_out(ram_dq_out),
    .dq_in(ram_dq_in), .sel_col(sel_col), .row(row), .col(col)
  );

  edo_addr_mux #(.ROW_W(ROW_W), .COL_W(COL_W), .A_W(A_W)) u_amux (
    .row(row), .col(col), .sel_col(sel_col), .addr(ram_addr)
  );
endmodule

// File: rtl/edo_ctrl_chk.sv
module edo_ctrl_chk #(
  parameter int A_W  = 10,
  parameter int T_RP = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           ras_n,
  input logic           ucas_n,
  input logic           lcas_n,
  input logic           we_n,
  input logic           oe_n,
  input logic           dq_oe,
  input logic [A_W-1:0] addr,
  input logic           req_ready,
  input logic           rsp_valid
);
  logic [7:0] ras_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ras_hi <= '0;
    else if (!ras_n) ras_hi <= '0;
    else if (ras_hi != 8'hFF) ras_hi <= ras_hi + 1'b1;
  end

  assert_upper_not_late_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ucas_n) |-> $past(lcas_n));
  assert_lower_not_late_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lcas_n) |-> $past(ucas_n));
  assert_we_before_cas_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (($fell(ucas_n) || $fell(lcas_n)) && !we_n) |-> ($past(!we_n) && oe_n && dq_oe));
  assert_bus_turn_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(dq_oe && !oe_n));
  assert_addr_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ras_n) || $fell(ucas_n) || $fell(lcas_n)) |-> $stable(addr));
  assert_ras_precharge_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> (ras_hi >= 8'(T_RP)));
  assert_ready_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (ras_n && ucas_n && lcas_n && we_n && oe_n));
  assert_cbr_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ras_n) && !ucas_n) |-> (we_n && oe_n && $past(!ucas_n) && $past(!lcas_n)));
  assert_rsp_after_oe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(!oe_n));
  assert_rsp_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
endmodule

bind edo_ctrl edo_ctrl_chk #(.A_W(A_W), .T_RP(T_RP)) u_chk (
  .clk(clk), .rst_n(rst_n), .ras_n(ram_ras_n), .ucas_n(ram_ucas_n),
  .lcas_n(ram_lcas_n), .we_n(ram_we_n), .oe_n(ram_oe_n), .dq_oe(ram_dq_oe),
  .addr(ram_addr), .req_ready(req_ready), .rsp_valid(rsp_valid)
);

// File: tb/test_edo_ctrl.sv
`timescale 1ns/1ps
module test_edo_ctrl;
  localparam int ROW_W = 5, COL_W = 4, AW = ROW_W + COL_W, A_W = 5;
  localparam int PAUSE = 30, NREF = 8, RINT = 300;
  localparam int TRCD = 2, TRP = 2, TCSR = 1, TRASR = 3, TCASW = 2;
  localparam int TRAC = 6, TAA = 3, TCAC = 2;
  localparam int SAMPLE = 3;  // max(6-2-1, 3-1, 2)

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0] req_be = '0;
  logic req_ready, rsp_valid, ram_ras_n, ram_ucas_n, ram_lcas_n, ram_we_n, ram_oe_n, ram_dq_oe;
  logic [15:0] rsp_rdata, ram_dq_out, ram_dq_in;
  logic [A_W-1:0] ram_addr;

  always #4 clk = ~clk;

  edo_ctrl #(.ROW_W(ROW_W), .COL_W(COL_W), .PAUSE_CYC(PAUSE), .INIT_REF(NREF),
    .REF_INTERVAL(RINT), .T_RCD(TRCD), .T_RP(TRP), .T_CSR(TCSR), .T_RASR(TRASR),
    .T_CASW(TCASW), .T_RAC(TRAC), .T_AA(TAA), .T_CAC(TCAC)) i_edo_ctrl (.*);

  int compared = 0, mismatched = 0;
  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural memory and host-side shadow
  logic [15:0] mem [512];
  logic [15:0] shadow [512];
  logic [ROW_W-1:0] row_l = '0;
  logic [COL_W-1:0] col_l = '0;
  assign ram_dq_in = (!ram_oe_n && !ram_ras_n) ? mem[{row_l, col_l}] : 16'hDEAD;

  logic [15:0] exp_q [$];
  int cyc = 0, first_act = -1, init_cbr = 0, post_cbr = 0, last_cbr = -1;
  int ras_hi_run = 0, cas_lo_run = 0, oe_lo_run = 0, overlap = 0, rdy_bad = 0;
  int reads = 0, resps = 0;
  bit seen_ready = 0, p_ras = 1, p_u = 1, p_l = 1, p_we = 1, p_oe = 1, p_rsp = 0;
  logic [1:0] last_mask = '0;

  // monitor: samples on the falling edge, away from the design's update edge
  always @(negedge clk) begin
    if (rst_n) begin
      bit ras_fall, u_fall, l_fall;
      cyc++;
      ras_fall = p_ras && !ram_ras_n;
      u_fall = p_u && !ram_ucas_n;
      l_fall = p_l && !ram_lcas_n;
      if (first_act < 0 && !(ram_ras_n && ram_ucas_n && ram_lcas_n && ram_we_n && ram_oe_n))
        first_act = cyc;
      if (ras_fall) begin
        chk(ras_hi_run >= TRP, "R8 precharge", ras_hi_run, TRP);
        if (!ram_ucas_n && !ram_lcas_n) begin
          chk(cas_lo_run >= TCSR && ram_we_n && ram_oe_n, "R3 cbr order", cas_lo_run, TCSR);
          if (!seen_ready) init_cbr++;
          else begin
            chk(cyc - last_cbr <= RINT + 16, "R9 refresh gap", cyc - last_cbr, RINT);
            post_cbr++;
            last_cbr = cyc;
          end
        end else begin
          row_l = ram_addr[ROW_W-1:0];
          if (!seen_ready) chk(0, "R2 access during init", cyc, 0);
        end
      end
      if ((u_fall || l_fall) && !ram_ras_n && !p_ras) begin
        col_l = ram_addr[COL_W-1:0];
        last_mask = {u_fall, l_fall};
        if (!ram_we_n) begin
          chk(!p_we && ram_oe_n && ram_dq_oe, "R4 early write", {p_we, ram_oe_n, ram_dq_oe}, 3'b011);
          if (u_fall) mem[{row_l, col_l}][15:8] = ram_dq_out[15:8];
          if (l_fall) mem[{row_l, col_l}][7:0] = ram_dq_out[7:0];
        end
      end
      if (!p_oe && ram_oe_n) chk(oe_lo_run == SAMPLE, "R7 oe window", oe_lo_run, SAMPLE);
      if (ram_dq_oe && !ram_oe_n) overlap++;
      if (req_ready && !(ram_ras_n && ram_ucas_n && ram_lcas_n)) rdy_bad++;
      if (req_ready && !seen_ready) begin
        seen_ready = 1;
        chk(first_act >= PAUSE, "R1 pause length", first_act, PAUSE);
        chk(init_cbr == NREF, "R2 init refresh count", init_cbr, NREF);
        last_cbr = cyc;
      end
      if (rsp_valid) begin
        resps++;
        chk(!p_rsp, "R7 single-cycle valid", p_rsp, 0);
        if (exp_q.size() == 0) chk(0, "R10 unexpected response", rsp_rdata, 0);
        else begin
          logic [15:0] e;
          e = exp_q.pop_front();
          chk(rsp_rdata == e, "R6/R7 read data", rsp_rdata, e);
        end
      end
      ras_hi_run = ram_ras_n ? ras_hi_run + 1 : 0;
      cas_lo_run = (!ram_ucas_n && !ram_lcas_n) ? cas_lo_run + 1 : 0;
      oe_lo_run = !ram_oe_n ? oe_lo_run + 1 : 0;
      p_ras = ram_ras_n; p_u = ram_ucas_n; p_l = ram_lcas_n;
      p_we = ram_we_n; p_oe = ram_oe_n; p_rsp = rsp_valid;
    end
  end

  // driver: issues one request, records the expectation, waits for completion
  task automatic issue(input bit wr, input logic [AW-1:0] a, input logic [15:0] d, input logic [1:0] be);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
    if (wr) begin
      if (be[1]) shadow[a][15:8] = d[15:8];
      if (be[0]) shadow[a][7:0] = d[7:0];
    end else begin
      exp_q.push_back(shadow[a]);
      reads++;
    end
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R10 ready drops after accept", req_ready, 0);
    while (!req_ready) @(negedge clk);
    chk(last_mask == (wr ? be : 2'b11), "R5 cas mask", last_mask, wr ? be : 2'b11);
  endtask

  initial begin
    for (int i = 0; i < 512; i++) begin
      mem[i] = '0;
      shadow[i] = '0;
    end
    repeat (3) @(negedge clk);
    chk(ram_ras_n && ram_ucas_n && ram_lcas_n && ram_we_n && ram_oe_n && !req_ready && !rsp_valid,
        "R1 reset state", {ram_ras_n, ram_ucas_n, ram_lcas_n, ram_we_n, ram_oe_n, req_ready}, 6'b111110);
    rst_n = 1'b1;
    while (!seen_ready) @(negedge clk);
    issue(1, 9'h000, 16'h1234, 2'b11);
    issue(1, 9'h1FF, 16'hABCD, 2'b11);
    issue(1, 9'h0A5, 16'h5A5A, 2'b01);
    issue(1, 9'h0A5, 16'hC3C3, 2'b10);
    issue(1, 9'h021, 16'h0F0F, 2'b11);
    issue(1, 9'h121, 16'hF00F, 2'b11);
    issue(0, 9'h000, '0, 2'b11);
    issue(0, 9'h1FF, '0, 2'b00);
    issue(0, 9'h0A5, '0, 2'b11);
    issue(0, 9'h021, '0, 2'b11);
    issue(0, 9'h121, '0, 2'b11);
    repeat (3 * RINT) @(negedge clk);
    chk(post_cbr >= 2, "R9 periodic refresh", post_cbr, 2);
    for (int k = 0; k < 40; k++) issue(1, 9'(k * 13 + 7), 16'(k * 16'h0911 + 16'h3C), 2'(k % 3 + 1));
    for (int k = 0; k < 40; k++) issue(0, 9'(k * 13 + 7), '0, 2'b11);
    repeat (10) @(negedge clk);
    chk(exp_q.size() == 0 && reads == resps, "R10 one response per read", resps, reads);
    chk(overlap == 0, "R11 bus turnaround", overlap, 0);
    chk(rdy_bad == 0, "R10 ready only when idle", rdy_bad, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL watchdog R10 actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule